// File: doc/BRIEF.md
# Microcode Address Sequencer with Fetch and Panel Control

This block produces the address of the microword that the control store must present in every microcycle of a small 8-bit microprogrammed computer. While the machine runs, each instruction takes two fixed fetch microcycles. Execution microcycles follow them, and their address is the instruction opcode joined to a 2-bit step count. The current microword carries a 2-bit end code. That code, together with the ALU zero flag, decides whether the instruction finishes or moves to its next step.

While halted, the block stays idle until a panel action strobe arrives. It then runs exactly one microcycle of the panel routine that the panel function code selects, and returns to idle. A run request is acted on only between instructions. A program-counter reset request replaces the address of the first fetch microcycle with the reset-PC panel routine.

The control store, datapath and ALU are outside this block. The end code and zero flag belong to the microword at the address currently driven, and they are fed back in the same cycle.

Top module: `useq_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) gives phase 0 (idle) and uaddr 0x00 after that edge. The step count also returns to T0. Phase codes are 0 idle, 1 fetch, 2 execute and 3 panel.
- R2: In the execute phase, uaddr equals {ir_byte[7:2], T}, where T is the 2-bit step count (T0=0 to T3=3). The register selector bits ir_byte[1:0] never reach uaddr.
- R3: In execute, end_ctl decides whether the instruction ends this cycle. Code 0 never ends it. Code 1 ends it when alu_zero is 0. Code 2 ends it when alu_zero is 1. Code 3 always ends it. A step that does not end is followed by the next step.
- R4: The step count stops at T3. A step at T3 that does not end is followed by T3 again, at the same uaddr.
- R5: The first fetch cycle (phase 1, uaddr 0xFE) is always followed by the second (phase 1, uaddr 0xFF). The second is always followed by execute step T0.
- R6: When an instruction ends, the next cycle is the first fetch cycle if run_req is 1, and idle (uaddr 0x00) if run_req is 0. From idle, run_req at 1 starts the first fetch cycle in the next cycle.
- R7: If pc_reset_req is 1 in the cycle that leads into the first fetch cycle, that fetch cycle uses uaddr 0xFC instead of 0xFE. The rest of the fetch is unchanged.
- R8: In idle with run_req at 0, a panel_strobe gives exactly one panel cycle (phase 3) at uaddr 0xF0 + 2*panel_fn, and idle follows it. Code 6 selects reset PC and code 7 selects increment PC. With run_req at 1, run takes priority over the strobe.
- R9: While an instruction runs, lowering run_req, panel_strobe and the panel function code have no effect until the instruction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_byte | input | 8 | Instruction register contents |
| end_ctl | input | 2 | End code of the current microword |
| alu_zero | input | 1 | ALU result is zero in this microcycle |
| run_req | input | 1 | Run (1) or halt (0) request |
| panel_fn | input | 3 | Panel function code |
| panel_strobe | input | 1 | Panel action strobe |
| pc_reset_req | input | 1 | Request to reset the program counter |
| uaddr | output | 8 | Microcode address for this microcycle |
| phase | output | 2 | 0 idle, 1 fetch, 2 execute, 3 panel |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 2-bit step count, a 3-bit panel code and an 8-bit instruction byte. With these values all eight panel routines, both fetch addresses and the reset-PC substitution produce the exact addresses listed above. A 2-bit step count reaches T3 within four microcycles, so long runs of continuing end codes hold the count at its limit and exercise the saturation. Random opcodes cover every 6-bit opcode field, and the bench confirms that the selector bits never appear in the address.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_EXEC  = 2'd2,
    PH_PANEL = 2'd3
  } phase_t;

  // End-code values of the microword end field
  localparam logic [1:0] END_GO    = 2'd0;
  localparam logic [1:0] END_NZ    = 2'd1;
  localparam logic [1:0] END_Z     = 2'd2;
  localparam logic [1:0] END_ALWAY = 2'd3;
endpackage

// File: rtl/useq_end_eval.sv
module useq_end_eval
  import useq_pkg::*;
(
  input  logic [1:0] end_ctl,
  input  logic       alu_zero,
  output logic       done
);
  always_comb begin
    case (end_ctl)
      END_GO:  done = 1'b0;
      END_NZ:  done = ~alu_zero;
      END_Z:   done = alu_zero;
      default: done = 1'b1;
    endcase
  end
endmodule

// File: rtl/useq_cycle_ctr.sv
module useq_cycle_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          adv,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (adv && (cnt != CNT_MAX)) cnt <= cnt + 1'b1;
  end

  // R4: the step count never wraps from its top value to anything but a clear
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clear) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/useq_mode_fsm.sv
module useq_mode_fsm
  import useq_pkg::*;
#(
  parameter int AW  = 8,
  parameter int FNW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_req,
  input  logic           panel_strobe,
  input  logic [FNW-1:0] panel_fn,
  input  logic           pc_reset_req,
  input  logic           exec_done,
  output phase_t         phase_q,
  output logic [AW-1:0]  fix_addr_q,
  output logic           cnt_clear,
  output logic           cnt_adv
);
  localparam logic [AW-1:0] ONES     = '1;
  localparam logic [AW-1:0] F1_ADDR  = ONES;
  localparam logic [AW-1:0] F0_ADDR  = ONES - 1;
  localparam logic [AW-1:0] RST_ADDR = ONES - 3;
  localparam int            TOPW     = AW - FNW - 1;
  localparam logic [TOPW-1:0] PNL_TOP = '1;

  typedef enum logic [2:0] {S_IDLE, S_PANEL, S_F0, S_F1, S_EX} st_t;

  st_t           st_q, st_d;
  phase_t        ph_d;
  logic [AW-1:0] addr_d;
  logic [AW-1:0] f0_pick;

  assign f0_pick = pc_reset_req ? RST_ADDR : F0_ADDR;

  always_comb begin
    st_d   = st_q;
    ph_d   = phase_q;
    addr_d = fix_addr_q;
    case (st_q)
      S_IDLE: begin
        if (run_req) begin
          st_d = S_F0; ph_d = PH_FETCH; addr_d = f0_pick;
        end else if (panel_strobe) begin
          st_d = S_PANEL; ph_d = PH_PANEL; addr_d = {PNL_TOP, panel_fn, 1'b0};
        end else begin
          ph_d = PH_IDLE; addr_d = '0;
        end
      end
      S_PANEL: begin
        st_d = S_IDLE; ph_d = PH_IDLE; addr_d = '0;
      end
      S_F0: begin
        st_d = S_F1; ph_d = PH_FETCH; addr_d = F1_ADDR;
      end
      S_F1: begin
        st_d = S_EX; ph_d = PH_EXEC; addr_d = '0;
      end
      default: begin
        if (exec_done) begin
          if (run_req) begin
            st_d = S_F0; ph_d = PH_FETCH; addr_d = f0_pick;
          end else begin
            st_d = S_IDLE; ph_d = PH_IDLE; addr_d = '0;
          end
        end else begin
          st_d = S_EX; ph_d = PH_EXEC; addr_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      phase_q    <= PH_IDLE;
      fix_addr_q <= '0;
    end else begin
      st_q       <= st_d;
      phase_q    <= ph_d;
      fix_addr_q <= addr_d;
    end
  end

  assign cnt_clear = (st_q != S_EX) || exec_done;
  assign cnt_adv   = (st_q == S_EX) && !exec_done;

  // R6: an ending instruction with run dropped goes to idle
  a_r6_halt_at_end: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXEC && exec_done && !run_req) |=> (phase_q == PH_IDLE));

  // R9: a step that does not end stays in execute whatever the run and panel inputs do
  a_r9_hold_exec: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXEC && !exec_done) |=> (phase_q == PH_EXEC));

  // R8: a panel cycle lasts exactly one microcycle
  a_r8_panel_once: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PANEL) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/useq_addr_gen.sv
module useq_addr_gen
  import useq_pkg::*;
#(
  parameter int AW  = 8,
  parameter int CW  = 2,
  parameter int FNW = 3,
  parameter int IRW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IRW-1:0] ir_byte,
  input  logic [1:0]     end_ctl,
  input  logic           alu_zero,
  input  logic           run_req,
  input  logic [FNW-1:0] panel_fn,
  input  logic           panel_strobe,
  input  logic           pc_reset_req,
  output logic [AW-1:0]  uaddr,
  output logic [1:0]     phase
);
  localparam int            OPW     = AW - CW;
  localparam logic [AW-1:0] F1_ADDR = '1;
  localparam logic [AW-1:0] F0_ADDR = F1_ADDR - 1;
  localparam logic [AW-1:0] RS_ADDR = F1_ADDR - 3;

  phase_t        ph_q;
  logic [AW-1:0] fix_addr;
  logic [CW-1:0] step;
  logic          done, clr, adv;

  useq_end_eval u_end (
    .end_ctl (end_ctl),
    .alu_zero(alu_zero),
    .done    (done)
  );

  useq_cycle_ctr #(.CW(CW)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .clear(clr),
    .adv  (adv),
    .cnt  (step)
  );

  useq_mode_fsm #(.AW(AW), .FNW(FNW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .run_req     (run_req),
    .panel_strobe(panel_strobe),
    .panel_fn    (panel_fn),
    .pc_reset_req(pc_reset_req),
    .exec_done   (done),
    .phase_q     (ph_q),
    .fix_addr_q  (fix_addr),
    .cnt_clear   (clr),
    .cnt_adv     (adv)
  );

  // Opcode field is taken live from the instruction register, loaded in the second fetch cycle
  assign uaddr = (ph_q == PH_EXEC) ? {ir_byte[IRW-1 -: OPW], step} : fix_addr;
  assign phase = ph_q;

  // R1: reset returns the sequencer to idle at address zero
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (phase == PH_IDLE && uaddr == '0));

  // R5: first fetch cycle is followed by the second
  a_r5_f0_then_f1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH && (uaddr == F0_ADDR || uaddr == RS_ADDR)) |=>
    (phase == PH_FETCH && uaddr == F1_ADDR));

  // R5: second fetch cycle is followed by step T0
  a_r5_f1_then_t0: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH && uaddr == F1_ADDR) |=>
    (phase == PH_EXEC && uaddr[CW-1:0] == '0));

  // R3: unconditional end leaves execute, unconditional continue stays
  a_r3_end_always: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && end_ctl == END_ALWAY) |=> (phase != PH_EXEC));
  a_r3_go_always: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && end_ctl == END_GO) |=> (phase == PH_EXEC));

  // R4: a non-ending step at T3 repeats the same step
  a_r4_repeat_t3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && uaddr[CW-1:0] == '1 && end_ctl == END_GO) |=>
    (phase == PH_EXEC && uaddr[CW-1:0] == '1));
endmodule

// File: tb/useq_addr_gen_test.sv
`timescale 1ns/1ps
module useq_addr_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ir_byte = 8'h00;
  logic [1:0] end_ctl = 2'd0;
  logic       alu_zero = 1'b0;
  logic       run_req = 1'b0;
  logic [2:0] panel_fn = 3'd0;
  logic       panel_strobe = 1'b0;
  logic       pc_reset_req = 1'b0;
  logic [7:0] uaddr;
  logic [1:0] phase;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  useq_addr_gen uut (
    .clk(clk), .rst(rst), .ir_byte(ir_byte), .end_ctl(end_ctl),
    .alu_zero(alu_zero), .run_req(run_req), .panel_fn(panel_fn),
    .panel_strobe(panel_strobe), .pc_reset_req(pc_reset_req),
    .uaddr(uaddr), .phase(phase)
  );

  // Behavioural reference model: phase 0 idle, 1 fetch, 2 exec, 3 panel
  int    m_ph = 0, m_prev = 0, m_addr = 0, m_cnt = 0;
  string m_tag = "R1";

  function automatic bit ends(int code, bit z);
    if (code == 0) return 1'b0;
    if (code == 1) return !z;
    if (code == 2) return z;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    m_prev = m_ph;
    if (rst) begin
      m_ph = 0; m_addr = 0; m_cnt = 0; m_tag = "R1";
    end else if (m_ph == 0) begin
      if (run_req) begin
        m_ph = 1; m_addr = pc_reset_req ? 'hFC : 'hFE;
        m_tag = pc_reset_req ? "R7" : "R6";
      end else if (panel_strobe) begin
        m_ph = 3; m_addr = 'hF0 + 2 * panel_fn; m_tag = "R8";
      end else begin
        m_addr = 0; m_tag = "R8";
      end
    end else if (m_ph == 3) begin
      m_ph = 0; m_addr = 0; m_tag = "R8";
    end else if (m_ph == 1) begin
      if (m_addr == 'hFF) begin
        m_ph = 2; m_cnt = 0; m_tag = "R5";
      end else begin
        m_addr = 'hFF; m_tag = "R5";
      end
    end else begin
      if (ends(end_ctl, alu_zero)) begin
        m_cnt = 0;
        if (run_req) begin
          m_ph = 1; m_addr = pc_reset_req ? 'hFC : 'hFE;
          m_tag = pc_reset_req ? "R7" : "R3";
        end else begin
          m_ph = 0; m_addr = 0; m_tag = "R6";
        end
      end else begin
        if (m_cnt < 3) begin
          m_cnt = m_cnt + 1; m_tag = "R3";
        end else m_tag = "R4";
        if (!run_req || panel_strobe) m_tag = "R9";
      end
    end
  end

  task automatic check(string tag, int act_ph, int act_a, int exp_ph, int exp_a);
    checks++;
    if (act_ph != exp_ph || act_a != exp_a) begin
      failures++;
      $display("FAIL %s actual phase=%0d uaddr=%02h expected phase=%0d uaddr=%02h",
               tag, act_ph, act_a, exp_ph, exp_a);
    end
  endtask

  task automatic drive(int seg);
    int p;
    p = $urandom_range(0, 99);
    panel_fn     = 3'($urandom_range(0, 7));
    panel_strobe = ($urandom_range(0, 99) < 40);
    alu_zero     = ($urandom_range(0, 99) < 30);
    pc_reset_req = ($urandom_range(0, 99) < 10);
    case (seg)
      0: begin run_req = 1'b0; end_ctl = 2'($urandom_range(0, 3)); end
      1: begin run_req = 1'b1; end_ctl = 2'($urandom_range(0, 3)); end
      2: begin
        run_req = ($urandom_range(0, 99) < 90);
        end_ctl = (p < 60) ? 2'd0 : 2'd2;
        alu_zero = ($urandom_range(0, 99) < 15);
      end
      default: begin
        if ($urandom_range(0, 99) < 30) run_req = ~run_req;
        end_ctl = 2'($urandom_range(0, 3));
      end
    endcase
  endtask

  initial begin
    int exp_a;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", phase, uaddr, 0, 0);
    rst = 1'b0;
    for (int k = 0; k < 3400; k++) begin
      @(negedge clk);
      if (m_ph == 2 && m_prev == 1) ir_byte = 8'($urandom_range(0, 255));
      #1;
      exp_a = (m_ph == 2) ? ((ir_byte & 'hFC) | m_cnt) : m_addr;
      if (m_ph == 2) check((m_cnt == 3) ? "R4" : "R2", phase, uaddr, m_ph, exp_a);
      else check(m_tag, phase, uaddr, m_ph, exp_a);
      if (k == 3000 || k == 3001) begin
        rst = 1'b1; run_req = 1'b1;
      end else begin
        rst = 1'b0;
        drive((k < 200) ? 0 : (k < 1200) ? 1 : (k < 2000) ? 2 :
              (k < 3000) ? 3 : 0);
      end
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule